// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C master's command engine. Software writes a 16-bit command word. If the word asks for a receive, the engine generates nine SCL clocks. It shifts in eight data bits from SDA, most significant bit first. On the ninth clock it either pulls SDA low to acknowledge or leaves it released. The byte lands in a receive-byte register, and a receive-done flag is raised in the interrupt status register.

A receive-last command gives a not-acknowledge, which tells the target that this was the final byte. The engine will not fetch a new byte while the previous receive-done flag is still pending; the command waits until software clears the flag. A readable transfer-state field shows when the bus is busy receiving. START, address and STOP phases are handled by neighbouring logic.

Top module: `i2c_rx_seq`

## Requirements
- R1: After reset, cmd_o, sts_o, rx_byte_o and xfer_state_o are all zero, busy_o is low, scl_o is high and sda_oe_o is low.
- R2: A command write while busy_o is low replaces cmd_o. If bit 3 (receive) or bit 4 (receive-last) of the new word is set, busy_o goes high from the next cycle.
- R3: xfer_state_o reads 3 (receiving) from the cycle a byte starts until it completes, then reads 1 (active); it reads 0 before any receive.
- R4: A receive produces nine SCL periods, each HALF_CYC cycles low then HALF_CYC cycles high. SDA is sampled on each of the first eight rising edges, most significant bit first, and scl_o is high when no byte is in progress.
- R5: On a successful receive the sampled byte appears on rx_byte_o.
- R6: During the ninth SCL period sda_oe_o is high (ACK) when bit 4 is clear, and stays low (NACK) when bit 4 is set.
- R7: When the byte completes, bits 3 and 4 of cmd_o clear, the other command bits keep their value, and busy_o falls.
- R8: A successful receive sets sts_o bit 2 (receive-done).
- R9: If bus_err_i is high on any cycle while the byte is in progress, rx_byte_o is loaded with 0xFF and sts_o bit 2 is not set.
- R10: While sts_o bit 2 is set, a receive command stays pending: busy_o stays high, no SCL activity occurs and xfer_state_o does not change. The byte starts on the second cycle after the flag is cleared.
- R11: An accepted command write clears every sts_o bit except bit 2, which keeps its value.
- R12: A command write while busy_o is high has no effect on cmd_o or sts_o.
- R13: sts_evt_i sets the matching sts_o bits (bit 2 excepted), and sts_clr_we_i with sts_clr_i clears the bits written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 16 | Command word |
| sts_clr_we_i | input | 1 | Status write-one-to-clear strobe |
| sts_clr_i | input | 8 | Status bits to clear |
| sts_evt_i | input | 8 | Status event pulses from neighbouring logic |
| sda_i | input | 1 | SDA line as seen on the bus |
| bus_err_i | input | 1 | Bus fault during the current byte |
| scl_o | output | 1 | SCL level driven by the master |
| sda_oe_o | output | 1 | Pull SDA low when high |
| cmd_o | output | 16 | Command register |
| sts_o | output | 8 | Interrupt status register |
| rx_byte_o | output | 8 | Receive-byte register |
| xfer_state_o | output | 4 | Transfer-state code |
| busy_o | output | 1 | Receive command pending or in progress |

## Verification
The embedded properties check on every cycle that:
- the state code reads "receiving" whenever the shifter runs;
- a shift only begins when the receive-done flag was clear;
- completion drops busy;
- a write during a busy period leaves the command untouched;
- an accepted write preserves receive-done;
- a failed receive yields 0xFF without the flag;
- the shift register only moves on a rising SCL.

Only the bench's scenarios show the following, by comparing against an independent model on every clock:
- that the sampled bit order and byte value are correct;
- that the ACK/NACK choice follows bit 4;
- the exact SCL waveform;
- that the pending command starts on the right cycle after the flag is cleared.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  parameter int CMD_W       = 16;
  parameter int STS_W       = 8;
  parameter int BYTE_W      = 8;
  parameter int CMD_RX_BIT  = 3;
  parameter int CMD_RXL_BIT = 4;
  parameter int STS_RXD_BIT = 2;

  typedef enum logic [3:0] {
    XS_IDLE   = 4'h0,
    XS_ACTIVE = 4'h1,
    XS_RECV   = 4'h3
  } xfer_state_e;
endpackage

// File: rtl/i2c_rx_bit_timer.sv
module i2c_rx_bit_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0); // R4
endmodule

// File: rtl/i2c_rx_byte_shifter.sv
module i2c_rx_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              nack_i,
  input  logic              tick_i,
  input  logic              sda_i,
  input  logic              err_i,
  output logic              active_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int NBITS = BYTE_W + 1;
  localparam int BW    = $clog2(NBITS);
  localparam logic [BW-1:0] ACK_IDX = BW'(BYTE_W);

  logic              active_q, phase_q, scl_q, nack_q, fail_q, done_q;
  logic [BW-1:0]     bitn_q;
  logic [BYTE_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      scl_q    <= 1'b1;
      nack_q   <= 1'b0;
      fail_q   <= 1'b0;
      done_q   <= 1'b0;
      bitn_q   <= '0;
      shreg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        scl_q    <= 1'b0;
        bitn_q   <= '0;
        fail_q   <= 1'b0;
        nack_q   <= nack_i;
      end else if (active_q) begin
        if (err_i) fail_q <= 1'b1;
        if (tick_i) begin
          if (!phase_q) begin
            // rising SCL: sample data bits only
            phase_q <= 1'b1;
            scl_q   <= 1'b1;
            if (bitn_q != ACK_IDX) shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
          end else if (bitn_q == ACK_IDX) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bitn_q  <= bitn_q + 1'b1;
            phase_q <= 1'b0;
            scl_q   <= 1'b0;
          end
        end
      end
    end
  end

  assign active_o = active_q;
  assign scl_o    = scl_q;
  assign sda_oe_o = active_q && (bitn_q == ACK_IDX) && !nack_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign byte_o   = shreg_q;

  AST_SCL_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> scl_q); // R4
  AST_SHIFT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shreg_q != $past(shreg_q)) |-> $rose(scl_q)); // R4
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !active_q && $past(active_q)); // R7
endmodule

// File: rtl/i2c_rx_seq.sv
module i2c_rx_seq
  import i2c_rx_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic              sts_clr_we_i,
  input  logic [STS_W-1:0]  sts_clr_i,
  input  logic [STS_W-1:0]  sts_evt_i,
  input  logic              sda_i,
  input  logic              bus_err_i,
  output logic              scl_o,
  output logic              sda_oe_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [STS_W-1:0]  sts_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [3:0]        xfer_state_o,
  output logic              busy_o
);
  localparam logic [STS_W-1:0] RXD_MASK = STS_W'(1) << STS_RXD_BIT;

  logic [CMD_W-1:0]  cmd_q;
  logic [STS_W-1:0]  sts_q, sts_d;
  logic [BYTE_W-1:0] rx_byte_q, shf_byte;
  xfer_state_e       xs_q;
  logic busy, wr_ok, start, tick;
  logic shf_active, shf_done, shf_fail;

  assign busy  = cmd_q[CMD_RX_BIT] | cmd_q[CMD_RXL_BIT];
  assign wr_ok = cmd_we_i && !busy;
  // pending receive waits for receive-done to be cleared
  assign start = busy && !sts_q[STS_RXD_BIT] && !shf_active && !shf_done;

  i2c_rx_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (shf_active),
    .tick_o (tick)
  );

  i2c_rx_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .nack_i   (cmd_q[CMD_RXL_BIT]),
    .tick_i   (tick),
    .sda_i    (sda_i),
    .err_i    (bus_err_i),
    .active_o (shf_active),
    .scl_o    (scl_o),
    .sda_oe_o (sda_oe_o),
    .done_o   (shf_done),
    .fail_o   (shf_fail),
    .byte_o   (shf_byte)
  );

  always_comb begin
    sts_d = sts_q;
    if (sts_clr_we_i) sts_d = sts_d & ~sts_clr_i;
    if (wr_ok)        sts_d = sts_d & RXD_MASK;
    sts_d = sts_d | (sts_evt_i & ~RXD_MASK);
    if (shf_done && !shf_fail) sts_d = sts_d | RXD_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      sts_q     <= '0;
      rx_byte_q <= '0;
      xs_q      <= XS_IDLE;
    end else begin
      sts_q <= sts_d;
      if (wr_ok) begin
        cmd_q <= cmd_wdata_i;
      end else if (shf_done) begin
        cmd_q[CMD_RX_BIT]  <= 1'b0;
        cmd_q[CMD_RXL_BIT] <= 1'b0;
      end
      if (shf_done) rx_byte_q <= shf_fail ? {BYTE_W{1'b1}} : shf_byte;
      if (start)         xs_q <= XS_RECV;
      else if (shf_done) xs_q <= XS_ACTIVE;
    end
  end

  assign cmd_o        = cmd_q;
  assign sts_o        = sts_q;
  assign rx_byte_o    = rx_byte_q;
  assign xfer_state_o = xs_q;
  assign busy_o       = busy;

  AST_STATE_WHILE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shf_active |-> xs_q == XS_RECV); // R3
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shf_active) |-> !$past(sts_q[STS_RXD_BIT])); // R10
  AST_CMD_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shf_done |=> !busy_o); // R7
  AST_KEEP_RXDONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok && !shf_done && !(sts_clr_we_i && sts_clr_i[STS_RXD_BIT])
    |=> sts_q[STS_RXD_BIT] == $past(sts_q[STS_RXD_BIT])); // R11
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && busy && !shf_done |=> $stable(cmd_q)); // R12
  AST_FAIL_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shf_done && shf_fail && !sts_q[STS_RXD_BIT]
    |=> rx_byte_q == {BYTE_W{1'b1}} && !sts_q[STS_RXD_BIT]); // R9
endmodule

// File: tb/i2c_rx_seq_test.sv
`timescale 1ns/1ps
module i2c_rx_seq_test;
  localparam int H   = 4;
  localparam int END = 18 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic sts_clr_we = 1'b0;
  logic [7:0] sts_clr = '0;
  logic [7:0] sts_evt = '0;
  logic sda = 1'b1;
  logic bus_err = 1'b0;
  logic scl, sda_oe, busy;
  logic [15:0] cmd;
  logic [7:0] sts, rx_byte;
  logic [3:0] xstate;

  always #2.5 clk = ~clk;

  i2c_rx_seq #(.HALF_CYC(H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .sts_clr_we_i(sts_clr_we), .sts_clr_i(sts_clr), .sts_evt_i(sts_evt),
    .sda_i(sda), .bus_err_i(bus_err), .scl_o(scl), .sda_oe_o(sda_oe),
    .cmd_o(cmd), .sts_o(sts), .rx_byte_o(rx_byte), .xfer_state_o(xstate),
    .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit done_run = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [15:0] m_cmd;
  logic [7:0]  m_sts, m_buf, m_src;
  int m_state, m_cnt;
  bit m_fail, m_nack;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_sts = 0; m_buf = 0; m_state = 0; m_cnt = 0; m_fail = 0; m_nack = 0;
    end else begin : mdl
      bit obusy, odone;
      int oc;
      logic [7:0] ns;
      obusy = m_cmd[3] | m_cmd[4];
      odone = m_sts[2];
      oc = m_cnt;
      ns = m_sts;
      if (sts_clr_we) ns = ns & ~sts_clr;
      if (cmd_we && !obusy) begin ns = ns & 8'h04; m_cmd = cmd_wdata; end
      ns = ns | (sts_evt & 8'hFB);
      if (oc >= 1) begin
        if (bus_err && oc <= END) m_fail = 1;
        if (oc == END + 1) begin
          m_cnt = 0; m_cmd[3] = 0; m_cmd[4] = 0; m_state = 1;
          if (m_fail) m_buf = 8'hFF;
          else begin m_buf = m_src; ns = ns | 8'h04; end
        end else m_cnt = oc + 1;
      end else if (obusy && !odone) begin
        m_cnt = 1; m_state = 3; m_fail = 0; m_nack = m_cmd[4];
      end
      m_sts = ns;
    end
  end

  // target on the bus: drive data bits while SCL is low
  always @(negedge clk) begin
    int h;
    h = (m_cnt - 1) / H;
    if (m_cnt >= 1 && m_cnt <= END && h < 16) sda <= m_src[7 - h/2];
    else sda <= 1'b1;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      int h;
      bit e_scl, e_oe;
      h = (m_cnt - 1) / H;
      e_scl = 1; e_oe = 0;
      if (m_cnt >= 1 && m_cnt <= END) begin
        e_scl = (h % 2) == 1;
        e_oe  = (h >= 16) && !m_nack;
      end
      chk("R2 busy", busy, m_cmd[3] | m_cmd[4]);
      chk("R7/R12 cmd", cmd, m_cmd);
      chk("R8/R11/R13 sts", sts, m_sts);
      chk("R5/R9 rx_byte", rx_byte, m_buf);
      chk("R3 xfer_state", xstate, m_state);
      chk("R4 scl", scl, e_scl);
      chk("R6 sda_oe", sda_oe, e_oe);
    end
  end

  task automatic wr_cmd(input logic [15:0] w);
    @(negedge clk); cmd_we = 1; cmd_wdata = w;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic clr_sts(input logic [7:0] m);
    @(negedge clk); sts_clr_we = 1; sts_clr = m;
    @(negedge clk); sts_clr_we = 0; sts_clr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cmd", cmd, 0);
    chk("R1 reset sts", sts, 0);
    chk("R1 reset byte", rx_byte, 0);
    chk("R1 reset state", xstate, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset scl", scl, 1);
    chk("R1 reset oe", sda_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // plain receive, ACK
    m_src = 8'hA5;
    wr_cmd(16'h0008);
    chk("R2 busy after cmd", busy, 1);
    repeat (10) @(negedge clk);
    chk("R3 receiving", xstate, 3);
    wait_idle();
    chk("R5 byte A5", rx_byte, 8'hA5);
    chk("R8 rxdone set", sts[2], 1);
    chk("R3 back to active", xstate, 1);

    // other flags cleared by a command write, receive-done kept
    @(negedge clk); sts_evt = 8'h21;
    @(negedge clk); sts_evt = 0;
    chk("R13 event set", sts, 8'h25);
    wr_cmd(16'h0100);
    chk("R11 write keeps rxdone only", sts, 8'h04);

    // hold off while receive-done pending
    m_src = 8'h3C;
    wr_cmd(16'h0190);
    repeat (30) @(negedge clk);
    chk("R10 pending busy", busy, 1);
    chk("R10 no scl activity", scl, 1);
    chk("R10 state unchanged", xstate, 1);
    clr_sts(8'h04);
    repeat (6) @(negedge clk);
    chk("R10 started", xstate, 3);
    // write while busy ignored
    @(negedge clk); sts_evt = 8'h40;
    @(negedge clk); sts_evt = 0;
    wr_cmd(16'hFFFF);
    chk("R12 cmd unchanged", cmd, 16'h0190);
    chk("R12 sts unchanged", sts, 8'h40);
    wait_idle();
    chk("R6/R5 nack byte 3C", rx_byte, 8'h3C);
    chk("R7 other bits kept", cmd, 16'h0180);

    // failing receive
    clr_sts(8'hFF);
    m_src = 8'h12;
    wr_cmd(16'h0008);
    repeat (20) @(negedge clk);
    bus_err = 1;
    @(negedge clk); bus_err = 0;
    wait_idle();
    chk("R9 byte FF", rx_byte, 8'hFF);
    chk("R9 rxdone clear", sts[2], 0);

    // both bits set: NACK
    m_src = 8'h81;
    wr_cmd(16'h0018);
    wait_idle();
    chk("R6/R5 byte 81", rx_byte, 8'h81);
    chk("R7 both bits cleared", cmd, 16'h0000);

    repeat (3) @(negedge clk);
    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done_run = 1;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule